// File: doc/BRIEF.md
# Burst Transfer Address Generator

This block is the address half of a bus master. Software-independent logic upstream hands it a start address, a beat size and a burst code, and the block then produces the address-phase signals of an AHB-Lite burst, one beat at a time: address, transfer type, size and burst code. It moves to the next beat only when the slave accepts the current one, by holding HREADY high. When the data source upstream is not ready for the next beat, it marks the gap with BUSY cycles.

Both fixed-length bursts (incrementing or wrapping, with 4, 8 or 16 beats) and single transfers are generated. An undefined-length incrementing burst runs until a stop request arrives together with an accepted beat. Wrapping bursts fold at a boundary set by the beat size times the beat count. A start request is refused with a one-cycle error pulse when it cannot be issued legally. The refused cases are a fixed incrementing burst that would cross a 1 KB page, a beat size wider than the data bus, and a start address that is not aligned to the beat size. An undefined-length burst that reaches a 1 KB page edge restarts with a fresh NONSEQ beat. A one-cycle done pulse marks the end of every burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, htrans_o is IDLE (00) and busy_o, done_o and err_o are all 0.
- R2: A valid start_i seen at a clock edge while busy_o is low makes the outputs show NONSEQ (10) at start_addr_i, with hsize_o and hburst_o equal to the request, after that edge. A start_i seen while busy_o is high is ignored.
- R3: The burst codes are: 000 single, 001 undefined-length incrementing, 010/011 wrapping/incrementing of 4 beats, 100/101 of 8 beats, 110/111 of 16 beats. A fixed-length burst ends after exactly that many accepted beats, and stop_i has no effect on it.
- R4: In an incrementing burst, each SEQ (11) beat has the address of the previously accepted beat plus 2^hsize bytes.
- R5: In a wrapping burst, each beat address stays inside the aligned block of 2^hsize times the beat count in bytes, and wraps to the bottom of that block. For example, a 4-beat burst of 4-byte beats starting at 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R6: While hready_i is low and a transfer is shown, haddr_o and htrans_o hold their values. hsize_o and hburst_o stay constant for the whole burst.
- R7: If src_ready_i is low when a non-final beat is accepted, the next cycle shows BUSY (01) with the address of the next beat. The burst resumes with SEQ at that address at the first edge where hready_i and src_ready_i are both high.
- R8: An undefined-length burst ends with the beat that is accepted while stop_i is high.
- R9: When the next beat of an undefined-length burst lies on a 1 KB page edge, that beat is issued as NONSEQ. While the source is not ready, IDLE is shown in its place. A SEQ beat of an incrementing burst never lies on a page edge.
- R10: A start is refused, with err_o high for one cycle and htrans_o staying IDLE, in three cases: a fixed incrementing burst whose page offset plus its beat count times 2^size exceeds 1024; a size above the bus width code (2, for 4 bytes); or a start address not aligned to 2^size.
- R11: done_o is high for exactly the one cycle after the last beat is accepted. In that cycle htrans_o is IDLE and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a burst |
| start_addr_i | input | ADDR_W | First beat address |
| size_i | input | 3 | Beat size code, bytes = 2^size |
| burst_i | input | 3 | Burst code (see R3) |
| stop_i | input | 1 | Ends an undefined-length burst with the accepted beat |
| src_ready_i | input | 1 | Data source ready for the next beat |
| hready_i | input | 1 | Slave accepts the current beat |
| haddr_o | output | ADDR_W | Address-phase address |
| htrans_o | output | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hsize_o | output | 3 | Beat size code |
| hburst_o | output | 3 | Burst code |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse after the last beat is accepted |
| err_o | output | 1 | One-cycle pulse after a refused start |

## Verification
A wrong beat counter or a wrong wrap mask shows up at the very next accepted beat: the address on haddr_o leaves its expected arithmetic sequence, or the transfer ends a beat early or late. When that happens, done_o rises in the wrong cycle. A lost pending-restart flag turns the first beat past a page edge into SEQ in the cycle that beat appears. A stall-handling fault changes haddr_o or htrans_o during a low-HREADY cycle, where the next sample catches it. The bench sweeps every size and burst code over several start addresses, including page-edge and wrap-fold cases. It does this under three handshake patterns and compares each cycle against addresses computed from the start, the size and the beat index.

// File: rtl/burst_gen_pkg.sv
package burst_gen_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam int MAX_BEATS = 16;
  localparam int BEAT_W    = $clog2(MAX_BEATS) + 1;

  // beats of a burst code; the undefined-length code reports 1
  function automatic logic [BEAT_W-1:0] beat_count(input logic [2:0] code);
    case (code[2:1])
      2'd0:    beat_count = BEAT_W'(1);
      2'd1:    beat_count = BEAT_W'(4);
      2'd2:    beat_count = BEAT_W'(8);
      default: beat_count = BEAT_W'(16);
    endcase
  endfunction

  function automatic logic is_wrap(input logic [2:0] code);
    is_wrap = !code[0] && (code != 3'b000);
  endfunction

  function automatic logic is_open(input logic [2:0] code);
    is_open = (code == 3'b001);
  endfunction

  function automatic logic is_fixed_incr(input logic [2:0] code);
    is_fixed_incr = code[0] && (code[2:1] != 2'b00);
  endfunction

endpackage

// File: rtl/burst_start_check.sv
module burst_start_check
  import burst_gen_pkg::*;
#(
  parameter int BUS_SIZE_LOG2 = 2,
  parameter int PAGE_LOG2     = 10
) (
  input  logic [PAGE_LOG2-1:0] addr_low_i,
  input  logic [2:0]           size_i,
  input  logic [2:0]           burst_i,
  output logic                 ok_o
);
  localparam int SPAN_W = (PAGE_LOG2 + 2 > 12) ? PAGE_LOG2 + 2 : 12;

  logic [SPAN_W-1:0]    span;
  logic [SPAN_W-1:0]    limit;
  logic [SPAN_W-1:0]    reach;
  logic [PAGE_LOG2-1:0] low_mask;
  logic                 crosses;
  logic                 too_wide;
  logic                 unaligned;

  always_comb begin
    span      = SPAN_W'(beat_count(burst_i)) << size_i;
    limit     = SPAN_W'(1) << PAGE_LOG2;
    reach     = SPAN_W'(addr_low_i) + span;
    crosses   = is_fixed_incr(burst_i) && (reach > limit);
    too_wide  = size_i > 3'(BUS_SIZE_LOG2);
    low_mask  = (PAGE_LOG2'(1) << size_i) - PAGE_LOG2'(1);
    unaligned = |(addr_low_i & low_mask);
    ok_o      = !(crosses || too_wide || unaligned);
  end

endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        burst_i,
  output logic [ADDR_W-1:0] next_o,
  output logic              page_edge_o
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] bumped;

  always_comb begin
    step        = ADDR_W'(1) << size_i;
    wrap_mask   = (ADDR_W'(beat_count(burst_i)) << size_i) - ADDR_W'(1);
    bumped      = addr_i + step;
    next_o      = is_wrap(burst_i) ? ((addr_i & ~wrap_mask) | (bumped & wrap_mask))
                                   : bumped;
    page_edge_o = (bumped[PAGE_LOG2-1:0] == '0);
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        burst_i,
  input  logic              start_ok_i,
  input  logic              stop_i,
  input  logic              src_ready_i,
  input  logic              hready_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              page_edge_i,
  output logic [ADDR_W-1:0] addr_o,
  output trans_e            trans_o,
  output logic [2:0]        size_o,
  output logic [2:0]        burst_o,
  output logic              active_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int LEFT_W = BEAT_W - 1;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  trans_e            trans_q, trans_d;
  logic [2:0]        size_q, size_d;
  logic [2:0]        burst_q, burst_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              restart_q, restart_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              upd_en;
  logic              last_beat;
  logic              edge_restart;

  assign upd_en = active_q ? hready_i : start_i;

  always_comb begin
    active_d     = active_q;
    addr_d       = addr_q;
    trans_d      = trans_q;
    size_d       = size_q;
    burst_d      = burst_q;
    left_d       = left_q;
    restart_d    = restart_q;
    done_d       = 1'b0;
    err_d        = 1'b0;
    last_beat    = is_open(burst_q) ? stop_i : (left_q == '0);
    edge_restart = is_open(burst_q) && page_edge_i;

    if (!active_q) begin
      if (start_i) begin
        if (start_ok_i) begin
          active_d  = 1'b1;
          addr_d    = start_addr_i;
          trans_d   = TR_NSEQ;
          size_d    = size_i;
          burst_d   = burst_i;
          left_d    = LEFT_W'(beat_count(burst_i) - BEAT_W'(1));
          restart_d = 1'b0;
        end else begin
          err_d = 1'b1;
        end
      end
    end else if (hready_i) begin
      if (trans_q[1]) begin
        if (last_beat) begin
          active_d = 1'b0;
          trans_d  = TR_IDLE;
          done_d   = 1'b1;
        end else begin
          addr_d = next_addr_i;
          left_d = left_q - LEFT_W'(1);
          if (src_ready_i) begin
            trans_d   = edge_restart ? TR_NSEQ : TR_SEQ;
            restart_d = 1'b0;
          end else begin
            trans_d   = edge_restart ? TR_IDLE : TR_BUSY;
            restart_d = edge_restart;
          end
        end
      end else if (src_ready_i) begin
        trans_d   = restart_q ? TR_NSEQ : TR_SEQ;
        restart_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      addr_q    <= '0;
      trans_q   <= TR_IDLE;
      size_q    <= '0;
      burst_q   <= '0;
      left_q    <= '0;
      restart_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      if (upd_en) begin
        active_q  <= active_d;
        addr_q    <= addr_d;
        trans_q   <= trans_d;
        size_q    <= size_d;
        burst_q   <= burst_d;
        left_q    <= left_d;
        restart_q <= restart_d;
      end
    end
  end

  assign addr_o   = addr_q;
  assign trans_o  = trans_q;
  assign size_o   = size_q;
  assign burst_o  = burst_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BUS_SIZE_LOG2 = 2,
  parameter int PAGE_LOG2     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        burst_i,
  input  logic              stop_i,
  input  logic              src_ready_i,
  input  logic              hready_i,
  output logic [ADDR_W-1:0] haddr_o,
  output logic [1:0]        htrans_o,
  output logic [2:0]        hsize_o,
  output logic [2:0]        hburst_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              start_ok;
  logic [ADDR_W-1:0] next_addr;
  logic              page_edge;
  trans_e            trans;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  burst_start_check #(
    .BUS_SIZE_LOG2(BUS_SIZE_LOG2),
    .PAGE_LOG2    (PAGE_LOG2)
  ) u_check (
    .addr_low_i(start_addr_i[PAGE_LOG2-1:0]),
    .size_i    (size_i),
    .burst_i   (burst_i),
    .ok_o      (start_ok)
  );

  burst_next_addr #(
    .ADDR_W   (ADDR_W),
    .PAGE_LOG2(PAGE_LOG2)
  ) u_next (
    .addr_i     (haddr_o),
    .size_i     (hsize_o),
    .burst_i    (hburst_o),
    .next_o     (next_addr),
    .page_edge_o(page_edge)
  );

  burst_seq #(
    .ADDR_W(ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .size_i      (size_i),
    .burst_i     (burst_i),
    .start_ok_i  (start_ok),
    .stop_i      (stop_i),
    .src_ready_i (src_ready_i),
    .hready_i    (hready_i),
    .next_addr_i (next_addr),
    .page_edge_i (page_edge),
    .addr_o      (haddr_o),
    .trans_o     (trans),
    .size_o      (hsize_o),
    .burst_o     (hburst_o),
    .active_o    (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign htrans_o = trans;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hready_i,
  input logic [ADDR_W-1:0] haddr_o,
  input logic [1:0]        htrans_o,
  input logic [2:0]        hsize_o,
  input logic [2:0]        hburst_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  logic [ADDR_W-1:0] prev_q;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] wmask;
  logic [4:0]        beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       prev_q <= '0;
    else if (hready_i && htrans_o[1]) prev_q <= haddr_o;
  end

  always_comb begin
    case (hburst_o[2:1])
      2'd1:    beats = 5'd4;
      2'd2:    beats = 5'd8;
      2'd3:    beats = 5'd16;
      default: beats = 5'd1;
    endcase
    step  = ADDR_W'(1) << hsize_o;
    wmask = (ADDR_W'(beats) << hsize_o) - ADDR_W'(1);
  end

  assert_first_nonseq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (htrans_o == 2'b10));

  assert_incr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_o == 2'b11 && hburst_o[0]) |-> (haddr_o == prev_q + step));

  assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_o == 2'b11 && !hburst_o[0]) |->
      ((((haddr_o - prev_q) & wmask) == (step & wmask)) &&
       ((haddr_o & ~wmask) == (prev_q & ~wmask))));

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready_i && htrans_o != 2'b00) |=> ($stable(haddr_o) && $stable(htrans_o)));

  assert_ctrl_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(hsize_o) && $stable(hburst_o)));

  assert_busy_inside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_o == 2'b01) |-> busy_o);

  assert_no_seq_on_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_o == 2'b11 && hburst_o[0]) |-> (haddr_o[PAGE_LOG2-1:0] != '0));

  assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && htrans_o == 2'b00));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (htrans_o == 2'b00 && !busy_o));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_LOG2(PAGE_LOG2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hready_i(hready_i),
  .haddr_o (haddr_o),
  .htrans_o(htrans_o),
  .hsize_o (hsize_o),
  .hburst_o(hburst_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] start_addr_i;
  logic [2:0]  size_i;
  logic [2:0]  burst_i;
  logic        stop_i;
  logic        src_ready_i;
  logic        hready_i;
  logic [31:0] haddr_o;
  logic [1:0]  htrans_o;
  logic [2:0]  hsize_o;
  logic [2:0]  hburst_o;
  logic        busy_o;
  logic        done_o;
  logic        err_o;

  int          total = 0;
  int          bad   = 0;
  logic [15:0] lfsr  = 16'hACE1;

  always #5 clk = ~clk;

  burst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .size_i(size_i), .burst_i(burst_i), .stop_i(stop_i), .src_ready_i(src_ready_i),
    .hready_i(hready_i), .haddr_o(haddr_o), .htrans_o(htrans_o), .hsize_o(hsize_o),
    .hburst_o(hburst_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int n_beats(input logic [2:0] code);
    case (code[2:1])
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] beat_addr(input logic [31:0] a, input logic [2:0] sz,
                                            input logic [2:0] bt, input int k);
    logic [31:0] st, msk;
    st = 32'd1 << sz;
    if (!bt[0] && bt != 3'b000) begin
      msk = (32'(n_beats(bt)) << sz) - 32'd1;
      return (a & ~msk) | ((a + 32'(k) * st) & msk);
    end
    return a + 32'(k) * st;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // one burst, checked every cycle; mode 0 all ready, 1 slave stalls, 2 stalls and source gaps
  task automatic run_burst(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] bt,
                           input int mode, input int ulen, input bit exp_err);
    bit          open_len, h, s, rs, pend, prev_h;
    int          n, k, cyc;
    logic [1:0]  exp_tr;
    logic [31:0] ea;
    string       tag;
    open_len = (bt == 3'b001);
    n        = open_len ? ulen : n_beats(bt);
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a; size_i = sz; burst_i = bt;
    stop_i = 1'b0; hready_i = 1'b1; src_ready_i = 1'b1;
    @(negedge clk);
    start_i      = (mode == 2);
    start_addr_i = ~a;
    if (exp_err) begin
      start_i = 1'b0;
      check("R10 err pulse", err_o, 1);
      check("R10 no transfer", htrans_o, 2'b00);
      check("R10 not busy", busy_o, 0);
      @(negedge clk);
      check("R10 err one cycle", err_o, 0);
      return;
    end
    k = 0; exp_tr = 2'b10; pend = 0; cyc = 0; prev_h = 1;
    while (k < n && cyc < 3000) begin
      ea = beat_addr(a, sz, bt, k);
      if (!prev_h)              tag = "R6 hold";
      else if (k == 0)          tag = "R2 first";
      else if (exp_tr == 2'b01) tag = "R7 busy";
      else if (exp_tr != 2'b11) tag = "R9 page restart";
      else if (!bt[0])          tag = "R5 wrap";
      else                      tag = "R4 incr";
      check({tag, " htrans"}, htrans_o, exp_tr);
      if (exp_tr != 2'b00) check({tag, " haddr"}, haddr_o, ea);
      check("R6 hsize", hsize_o, sz);
      check("R6 hburst", hburst_o, bt);
      step_lfsr();
      h = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      s = (mode == 2) ? (lfsr[1] | lfsr[2]) : 1'b1;
      hready_i    = h;
      src_ready_i = s;
      stop_i      = open_len ? (k == n - 1) : lfsr[5];  // R3: ignored for fixed length
      prev_h      = h;
      if (h) begin
        if (exp_tr[1]) begin
          k++;
          if (k < n) begin
            rs     = open_len && (beat_addr(a, sz, bt, k)[9:0] == 10'd0);
            exp_tr = s ? (rs ? 2'b10 : 2'b11) : (rs ? 2'b00 : 2'b01);
            pend   = rs && !s;
          end
        end else if (s) begin
          exp_tr = pend ? 2'b10 : 2'b11;
          pend   = 0;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0; stop_i = 1'b0;
    check(open_len ? "R8 end idle" : "R3 end idle", htrans_o, 2'b00);
    check("R11 done pulse", done_o, 1);
    check("R11 not busy", busy_o, 0);
    @(negedge clk);
    check("R11 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1-run act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] bases [6];
    bases = '{32'h000, 32'h034, 32'h1F6, 32'h3C8, 32'h3F8, 32'h7FE};
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0; size_i = '0; burst_i = '0;
    stop_i = 1'b0; src_ready_i = 1'b1; hready_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 htrans", htrans_o, 2'b00);
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 err", err_o, 0);

    for (int mode = 0; mode < 3; mode++)
      for (int sz = 0; sz < 3; sz++)
        for (int bt = 0; bt < 8; bt++)
          for (int b = 0; b < 6; b++) begin
            logic [31:0] a;
            bit          ex;
            a  = bases[b] & ~((32'd1 << sz) - 32'd1);
            ex = bt[0] && (bt[2:1] != 2'b00) &&
                 ((a % 1024) + n_beats(3'(bt)) * (1 << sz) > 1024);
            run_burst(a, 3'(sz), 3'(bt), mode, 7, ex);
          end

    // R5 example block, R10 extra refusals, long R8/R9 run
    run_burst(32'h34, 3'd2, 3'b010, 0, 1, 0);
    run_burst(32'h100, 3'd3, 3'b000, 0, 1, 1);
    run_burst(32'h101, 3'd1, 3'b011, 0, 1, 1);
    run_burst(32'h3E0, 3'd2, 3'b111, 0, 1, 1);
    run_burst(32'h7F0, 3'd2, 3'b001, 2, 40, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule